// File: doc/BRIEF.md
# Segment Line Capture Controller

This block gathers one display line of segment data from a parallel bus and turns it into a per-output drive code. A slow data clock and a line strobe arrive as plain inputs. Both are sampled on a faster system clock, and their falling edges act as events. When the strobe falls, the capture logic is armed. The first data-clock fall that sees enable-in low selects the device. From then on it counts words until the line is full, and further data is ignored until the next strobe.

When the device finishes, it drives enable-out low for one data-clock period. That pulse selects the next device in a chain, so several devices can share one bus and one clock and fill a wide panel in order. Each strobe fall copies the captured line into a line latch in one step. That latch feeds a two-bit level code per output. The code depends on the frame phase and is forced low while the display-off input is active.

Top module: `seg_line_capture`

## Requirements
- R1: With `nibble_mode` low, every data-clock fall taken while selected writes all eight bits of `bus_in` as one word, and a line is 30 words (30 clocks).
- R2: With `nibble_mode` high, two data-clock falls make one word: the first supplies bits 3..0 and the second bits 7..4, both from `bus_in[3:0]`. `bus_in[7:4]` has no effect, and a line takes 60 clocks.
- R3: After a strobe fall the device stays unselected until a data-clock fall sees enable-in low. Falls seen with enable-in high write nothing.
- R4: Once 240 bits are written the device ignores all data-clock falls until the next strobe fall.
- R5: Enable-out is high except for exactly one data-clock period. It goes low after the fall that completes the line and returns high at the next data-clock fall.
- R6: With `dir_fwd` high, bit b of word w lands on output w*8+b (output 0 is the first). With it low, it lands on output 239-(w*8+b).
- R7: With `dir_fwd` high, pin A is the enable input and pin B the enable output (`en_b_oe`=1, `en_a_oe`=0). With it low, the roles swap.
- R8: The drive outputs change only on a strobe fall, which copies all 240 captured bits at once. They do not change while data is being captured.
- R9: Each output's two-bit code is 2'b01 for frame 0 with bit 0, 2'b00 for frame 0 with bit 1, 2'b10 for frame 1 with bit 0, and 2'b11 for frame 1 with bit 1. The codes stand for the levels V43, V5, V12 and V0.
- R10: While `blank_n` is low, every output code is 2'b00 and the line latch clears. Capture into the data latch continues.
- R11: A strobe fall and a data-clock fall seen in the same system-clock cycle act as a strobe only, and that data sample is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all control inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| data_clk | input | 1 | Data clock; a falling edge takes one bus sample |
| line_strobe | input | 1 | Line strobe; a falling edge arms capture and loads the line latch |
| nibble_mode | input | 1 | 1 = 4-bit bus, 0 = 8-bit bus |
| dir_fwd | input | 1 | Output order and enable pin roles |
| frame | input | 1 | Frame phase for level coding |
| blank_n | input | 1 | Active-low display-off |
| bus_in | input | 8 | Parallel data bus |
| en_a_i | input | 1 | Enable pin A, input side |
| en_a_o | output | 1 | Enable pin A, output value |
| en_a_oe | output | 1 | Enable pin A acts as output |
| en_b_i | input | 1 | Enable pin B, input side |
| en_b_o | output | 1 | Enable pin B, output value |
| en_b_oe | output | 1 | Enable pin B acts as output |
| drive | output | 480 | Two-bit level code per output, output i at bits 2i+1..2i |

## Verification
The bench chains two instances and sends sixty words in a row. If the second device captured before the first device's enable-out pulse, or if the first device kept writing after its count ran out, the two images would be corrupted or shifted. The 4-bit test puts a different pattern on the idle upper bus bits, so a design that used them, or joined the nibbles in the wrong order, shows wrong bits. A strobe and a data-clock fall are made to coincide; a design that took that sample would shift the whole line by one word. The reverse-direction test holds the wrong enable pin low and sends garbage before selection, which exposes unswapped pin roles and early selection.

// File: rtl/seg_pkg.sv
// Shared types for the segment line capture block.
package seg_pkg;
    // Two-bit drive level code, ordered from lowest to highest level.
    typedef enum logic [1:0] {
        LVL_V5  = 2'b00,
        LVL_V43 = 2'b01,
        LVL_V12 = 2'b10,
        LVL_V0  = 2'b11
    } drv_lvl_t;

    // Capture control states.
    typedef enum logic [1:0] {
        CAP_IDLE  = 2'b00,
        CAP_ARMED = 2'b01,
        CAP_RUN   = 2'b10,
        CAP_DONE  = 2'b11
    } cap_state_t;
endpackage

// File: rtl/seg_in_sync.sv
// Registers the slow control inputs on the system clock and detects the
// falling edges of the data clock and the line strobe.
// Assumes the inputs change slowly compared to clk (several clk per phase).
module seg_in_sync #(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dclk_raw,
    input  logic             strobe_raw,
    input  logic [BUS_W-1:0] din_raw,
    input  logic             en_raw,
    output logic             dclk_fall,
    output logic             strobe_fall,
    output logic [BUS_W-1:0] din_s,
    output logic             en_s
);
    logic dclk_q, dclk_p, stb_q, stb_p;

    // Sample stage plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dclk_q <= 1'b0;
            dclk_p <= 1'b0;
            stb_q  <= 1'b0;
            stb_p  <= 1'b0;
            din_s  <= '0;
            en_s   <= 1'b1;
        end else begin
            dclk_q <= dclk_raw;
            dclk_p <= dclk_q;
            stb_q  <= strobe_raw;
            stb_p  <= stb_q;
            din_s  <= din_raw;
            en_s   <= en_raw;
        end
    end

    // Falling edge = high in history stage, low in sample stage.
    assign dclk_fall   = dclk_p & ~dclk_q;
    assign strobe_fall = stb_p & ~stb_q;
endmodule

// File: rtl/seg_capture_ctrl.sv
// Self-counting chip-select control. A strobe fall arms it; a data-clock
// fall with enable-in low selects it; after WORDS words it deselects and
// pulses enable-out low for one data-clock period.
// Assumes edge strobes are single-cycle pulses from seg_in_sync.
module seg_capture_ctrl import seg_pkg::*; #(
    parameter int NUM_OUT = 240,
    parameter int BUS_W   = 8,
    localparam int WORDS  = NUM_OUT / BUS_W,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int HALF   = BUS_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dclk_fall,
    input  logic             strobe_fall,
    input  logic             en_s,
    input  logic             nibble_mode,
    input  logic [BUS_W-1:0] din_s,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [BUS_W-1:0] wr_word,
    output logic             eo_n
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    cap_state_t       state_q;
    logic [IDX_W-1:0] widx_q;
    logic             half_q;
    logic [HALF-1:0]  nib_q;
    logic             eo_n_q;
    logic             take;

    // Decide whether this data-clock fall is a sample; strobe wins.
    always_comb begin
        take    = dclk_fall && !strobe_fall &&
                  ((state_q == CAP_ARMED && !en_s) || state_q == CAP_RUN);
        wr_en   = take && (!nibble_mode || half_q);
        wr_word = nibble_mode ? {din_s[HALF-1:0], nib_q} : din_s;
    end

    // Sequence the capture: arm, select, count words, pulse enable-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAP_IDLE;
            widx_q  <= '0;
            half_q  <= 1'b0;
            nib_q   <= '0;
            eo_n_q  <= 1'b1;
        end else if (strobe_fall) begin
            state_q <= CAP_ARMED;
            widx_q  <= '0;
            half_q  <= 1'b0;
            eo_n_q  <= 1'b1;
        end else if (dclk_fall) begin
            if (state_q == CAP_DONE) begin
                state_q <= CAP_IDLE;
                eo_n_q  <= 1'b1;
            end else if (take) begin
                if (nibble_mode && !half_q) begin
                    nib_q   <= din_s[HALF-1:0];
                    half_q  <= 1'b1;
                    state_q <= CAP_RUN;
                end else begin
                    half_q <= 1'b0;
                    widx_q <= widx_q + 1'b1;
                    if (widx_q == LAST_IDX) begin
                        state_q <= CAP_DONE;
                        eo_n_q  <= 1'b0;
                    end else begin
                        state_q <= CAP_RUN;
                    end
                end
            end
        end
    end

    assign wr_idx = widx_q;
    assign eo_n   = eo_n_q;

    AST_EO_FROM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eo_n_q) |-> $past(state_q) == CAP_RUN); // R5
    AST_EO_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (!eo_n_q && dclk_fall) |=> eo_n_q); // R5
endmodule

// File: rtl/seg_data_latch.sv
// Holds the line being captured. Each written word goes to a slot chosen
// by the word index and the direction; reversed order also mirrors bits.
// Assumes wr_idx stays below the word count while wr_en is high.
module seg_data_latch #(
    parameter int NUM_OUT = 240,
    parameter int BUS_W   = 8,
    localparam int WORDS  = NUM_OUT / BUS_W,
    localparam int IDX_W  = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [BUS_W-1:0]   wr_word,
    input  logic               dir_fwd,
    output logic [NUM_OUT-1:0] lat
);
    logic [BUS_W-1:0] word_rev;
    logic [IDX_W-1:0] slot;

    // Bit-mirrored copy of the word for the reverse order.
    for (genvar b = 0; b < BUS_W; b++) begin : g_rev
        assign word_rev[b] = wr_word[BUS_W-1-b];
    end

    // Slot counted from the far end in reverse order.
    assign slot = dir_fwd ? wr_idx : (IDX_W'(WORDS - 1) - wr_idx);

    // Write one word of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat <= '0;
        end else if (wr_en) begin
            lat[int'(slot)*BUS_W +: BUS_W] <= dir_fwd ? wr_word : word_rev;
        end
    end

    AST_WORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < WORDS)); // R1
endmodule

// File: rtl/seg_line_drive.sv
// Line latch loaded in one step on a strobe fall, cleared while display-off
// is active, and the per-output level coder.
// Assumes frame and blank_n are already glitch-free at the block input.
module seg_line_drive import seg_pkg::*; #(
    parameter int NUM_OUT = 240
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strobe_fall,
    input  logic                 blank_n,
    input  logic                 frame,
    input  logic [NUM_OUT-1:0]   lat,
    output logic [2*NUM_OUT-1:0] drive
);
    logic [NUM_OUT-1:0] line_q;

    // Copy the whole captured line, or clear it while blanked.
    always_ff @(posedge clk) begin
        if (!rst_n || !blank_n) begin
            line_q <= '0;
        end else if (strobe_fall) begin
            line_q <= lat;
        end
    end

    // Level code per output from frame phase and line bit.
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_lvl
        drv_lvl_t lvl;
        always_comb begin
            if (!blank_n)       lvl = LVL_V5;
            else if (frame)     lvl = line_q[i] ? LVL_V0 : LVL_V12;
            else                lvl = line_q[i] ? LVL_V5 : LVL_V43;
        end
        assign drive[2*i +: 2] = lvl;
    end

    AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |=> (line_q == '0)); // R10
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && !strobe_fall) |=> $stable(line_q)); // R8
endmodule

// File: rtl/seg_line_capture.sv
// Top level: cascaded segment line capture controller. Picks the enable
// pin roles from the direction input and ties sampling, control, data
// latch and line drive together.
// Assumes data_clk and line_strobe phases span several clk cycles.
module seg_line_capture #(
    parameter int NUM_OUT = 240,
    parameter int BUS_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 data_clk,
    input  logic                 line_strobe,
    input  logic                 nibble_mode,
    input  logic                 dir_fwd,
    input  logic                 frame,
    input  logic                 blank_n,
    input  logic [BUS_W-1:0]     bus_in,
    input  logic                 en_a_i,
    output logic                 en_a_o,
    output logic                 en_a_oe,
    input  logic                 en_b_i,
    output logic                 en_b_o,
    output logic                 en_b_oe,
    output logic [2*NUM_OUT-1:0] drive
);
    localparam int WORDS = NUM_OUT / BUS_W;
    localparam int IDX_W = $clog2(WORDS);

    logic             en_in, en_s, dclk_fall, strobe_fall, eo_n, wr_en;
    logic [BUS_W-1:0] din_s, wr_word;
    logic [IDX_W-1:0] wr_idx;
    logic [NUM_OUT-1:0] lat;

    // Enable pin roles follow the direction input.
    assign en_in   = dir_fwd ? en_a_i : en_b_i;
    assign en_a_oe = ~dir_fwd;
    assign en_b_oe = dir_fwd;
    assign en_a_o  = eo_n;
    assign en_b_o  = eo_n;

    seg_in_sync #(.BUS_W(BUS_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .dclk_raw(data_clk), .strobe_raw(line_strobe),
        .din_raw(bus_in), .en_raw(en_in), .dclk_fall(dclk_fall),
        .strobe_fall(strobe_fall), .din_s(din_s), .en_s(en_s)
    );

    seg_capture_ctrl #(.NUM_OUT(NUM_OUT), .BUS_W(BUS_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .dclk_fall(dclk_fall), .strobe_fall(strobe_fall),
        .en_s(en_s), .nibble_mode(nibble_mode), .din_s(din_s), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_word(wr_word), .eo_n(eo_n)
    );

    seg_data_latch #(.NUM_OUT(NUM_OUT), .BUS_W(BUS_W)) u_lat (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_word(wr_word), .dir_fwd(dir_fwd), .lat(lat)
    );

    seg_line_drive #(.NUM_OUT(NUM_OUT)) u_drv (
        .clk(clk), .rst_n(rst_n), .strobe_fall(strobe_fall), .blank_n(blank_n),
        .frame(frame), .lat(lat), .drive(drive)
    );
endmodule

// File: tb/sim_seg_line_capture.sv
// Directed bench: two chained instances, one task per scenario.
module sim_seg_line_capture;
    localparam int N = 240;
    localparam int W = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dclk = 1'b0, strobe = 1'b0, nib = 1'b0, dir0 = 1'b1, frame = 1'b0, blank_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic ena0_i = 1'b1, enb0_i = 1'b1;
    logic ena0_o, ena0_oe, enb0_o, enb0_oe, ena1_o, ena1_oe, enb1_o, enb1_oe;
    logic eo0;
    logic [2*N-1:0] drv0, drv1;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign eo0 = enb0_oe ? enb0_o : ena0_o;

    seg_line_capture u0 (
        .clk(clk), .rst_n(rst_n), .data_clk(dclk), .line_strobe(strobe),
        .nibble_mode(nib), .dir_fwd(dir0), .frame(frame), .blank_n(blank_n),
        .bus_in(din), .en_a_i(ena0_i), .en_a_o(ena0_o), .en_a_oe(ena0_oe),
        .en_b_i(enb0_i), .en_b_o(enb0_o), .en_b_oe(enb0_oe), .drive(drv0)
    );

    seg_line_capture u1 (
        .clk(clk), .rst_n(rst_n), .data_clk(dclk), .line_strobe(strobe),
        .nibble_mode(nib), .dir_fwd(1'b1), .frame(frame), .blank_n(blank_n),
        .bus_in(din), .en_a_i(eo0), .en_a_o(ena1_o), .en_a_oe(ena1_oe),
        .en_b_i(1'b1), .en_b_o(enb1_o), .en_b_oe(enb1_oe), .drive(drv1)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_code(input logic f, input logic b);
        case ({f, b})
            2'b00:   return 2'b01;
            2'b01:   return 2'b00;
            2'b10:   return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    function automatic logic [N-1:0] make_img(input int seed);
        logic [N-1:0] img;
        for (int w = 0; w < W; w++) img[w*8 +: 8] = 8'((w * 37 + seed * 91 + 5) ^ (seed << 3));
        return img;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic dclk_pulse(input logic [7:0] d);
        @(negedge clk);
        din = d;
        dclk = 1'b1;
        wait_clk(4);
        dclk = 1'b0;
        wait_clk(4);
    endtask

    task automatic strobe_pulse();
        @(negedge clk);
        strobe = 1'b1;
        wait_clk(4);
        strobe = 1'b0;
        wait_clk(6);
    endtask

    task automatic send_line(input logic [N-1:0] img);
        for (int w = 0; w < W; w++) begin
            if (nib) begin
                dclk_pulse({4'hA, img[w*8 +: 4]});
                dclk_pulse({4'h5, img[w*8+4 +: 4]});
            end else begin
                dclk_pulse(img[w*8 +: 8]);
            end
        end
    endtask

    // Compare all outputs of one instance with the image; one check per call.
    task automatic check_line(input int which, input logic [N-1:0] img, input bit fwd,
                              input bit blanked, input string req);
        int bad = 0;
        logic [1:0] a1 = 2'b00, e1 = 2'b00;
        for (int i = 0; i < N; i++) begin
            logic [1:0] act, exp;
            act = (which == 1) ? drv1[2*i +: 2] : drv0[2*i +: 2];
            exp = blanked ? 2'b00 : exp_code(frame, fwd ? img[i] : img[N-1-i]);
            if (act != exp) begin
                if (bad == 0) begin a1 = act; e1 = exp; end
                bad++;
            end
        end
        chk(bad == 0, req, $sformatf("inst%0d drive (first bad code)", which), 32'(a1), 32'(e1));
    endtask

    task automatic t_reset();
        check_line(0, '0, 1'b1, 1'b0, "R9 reset");
        chk(eo0 == 1'b1, "R5", "reset enable-out", 32'(eo0), 1);
        chk(ena0_oe == 1'b0 && enb0_oe == 1'b1, "R7", "fwd oe {a,b}", {ena0_oe, enb0_oe}, 2'b01);
    endtask

    task automatic t_cascade_wide();
        logic [N-1:0] a = make_img(1), b = make_img(2);
        nib = 1'b0; dir0 = 1'b1; ena0_i = 1'b0;
        @(negedge clk);
        strobe = 1'b1;
        wait_clk(3);
        chk(eo0 == 1'b1, "R5", "enable-out while strobe high", 32'(eo0), 1);
        strobe = 1'b0;
        wait_clk(6);
        send_line(a);
        chk(eo0 == 1'b0, "R5", "enable-out after last word", 32'(eo0), 0);
        dclk_pulse(b[7:0]);
        chk(eo0 == 1'b1, "R5", "enable-out after one period", 32'(eo0), 1);
        for (int w = 1; w < W; w++) dclk_pulse(b[w*8 +: 8]);
        chk(ena1_o == 1'b0, "R5", "second device enable-out", 32'(ena1_o), 0);
        check_line(0, '0, 1'b1, 1'b0, "R8 no change before strobe");
        strobe_pulse();
        check_line(0, a, 1'b1, 1'b0, "R1 R6 first device");
        check_line(1, b, 1'b1, 1'b0, "R3 R4 cascade second device");
        frame = 1'b1;
        wait_clk(2);
        check_line(0, a, 1'b1, 1'b0, "R9 frame high");
        frame = 1'b0;
        wait_clk(2);
    endtask

    task automatic t_nibble();
        logic [N-1:0] c = make_img(3), d = make_img(4);
        nib = 1'b1; dir0 = 1'b1; ena0_i = 1'b0;
        strobe_pulse();
        send_line(c);
        send_line(d);
        strobe_pulse();
        check_line(0, c, 1'b1, 1'b0, "R2 nibble first device");
        check_line(1, d, 1'b1, 1'b0, "R2 nibble second device");
        nib = 1'b0;
    endtask

    task automatic t_reverse();
        logic [N-1:0] e = make_img(5);
        dir0 = 1'b0; ena0_i = 1'b0; enb0_i = 1'b1;
        wait_clk(2);
        chk(ena0_oe == 1'b1 && enb0_oe == 1'b0, "R7", "rev oe {a,b}", {ena0_oe, enb0_oe}, 2'b10);
        strobe_pulse();
        for (int k = 0; k < 3; k++) dclk_pulse(8'hC3);
        enb0_i = 1'b0;
        send_line(e);
        chk(ena0_o == 1'b0, "R7", "rev enable-out on pin A", 32'(ena0_o), 0);
        strobe_pulse();
        check_line(0, e, 1'b0, 1'b0, "R3 R6 reverse order");
        dir0 = 1'b1; ena0_i = 1'b0; enb0_i = 1'b1;
        wait_clk(2);
    endtask

    task automatic t_blank();
        logic [N-1:0] f = make_img(6);
        blank_n = 1'b0;
        wait_clk(3);
        check_line(0, f, 1'b1, 1'b1, "R10 blanked outputs");
        strobe_pulse();
        send_line(f);
        blank_n = 1'b1;
        wait_clk(3);
        check_line(0, '0, 1'b1, 1'b0, "R10 line cleared");
        strobe_pulse();
        check_line(0, f, 1'b1, 1'b0, "R10 capture went on");
    endtask

    task automatic t_collide();
        logic [N-1:0] g = make_img(7);
        @(negedge clk);
        din = 8'hFF; dclk = 1'b1; strobe = 1'b1;
        wait_clk(4);
        dclk = 1'b0; strobe = 1'b0;
        wait_clk(4);
        send_line(g);
        strobe_pulse();
        check_line(0, g, 1'b1, 1'b0, "R11 strobe wins");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_cascade_wide();
        t_nibble();
        t_reverse();
        t_blank();
        t_collide();
        finish_run();
    end
endmodule